// File: doc/BRIEF.md
# I2C FIFO Threshold Interrupt Generator

This block sits between the register interface of an I2C controller and its serial bit engine. It holds one byte FIFO for each direction. The host pushes transmit bytes and pops receive bytes. The serial engine drains the transmit FIFO and fills the receive FIFO. From the FIFO fill levels, the programmed thresholds and the number of bytes the transfer still has to move, the block raises four data-movement status flags.

The status flags are sticky and cleared by writing ones. A per-flag enable mask folds them into a single interrupt line. Each direction has two flags. A "request" flag fires on the threshold level. A "tail" flag fires when the bytes left in the transfer cannot reach the threshold, so an interrupt-driven host can move the final bytes without waiting for a threshold event that will never come.

Top module: `fifo_irq_gen`

## Requirements
- R1: A write on `cfg_we` loads the TX threshold minus one from `cfg_wdata[5:0]` and the RX threshold minus one from `cfg_wdata[13:8]`. In the same cycle, bit 6 set empties the TX FIFO and bit 14 set empties the RX FIFO; the other FIFO is left unchanged.
- R2: Status bit 0 (TX request) becomes set when `rx_mode` is 0, the TX level is below the TX threshold, and `bytes_left` is at least the TX threshold.
- R3: Status bit 1 (TX tail) becomes set when `rx_mode` is 0, the TX level is below the TX threshold, and `bytes_left` is non-zero and below the TX threshold. Bits 0 and 1 are never raised together.
- R4: Status bit 2 (RX request) becomes set when `rx_mode` is 1, the RX level is at or above the RX threshold, and `bytes_left` is non-zero.
- R5: Status bit 3 (RX tail) becomes set when `rx_mode` is 1, `bytes_left` is 0 and the RX FIFO is not empty. It takes precedence over RX request: when both would hold, only bit 3 is raised.
- R6: Status bits are sticky and update one cycle after the levels or inputs change. A 1 on `sts_w1c[i]` clears bit i unless its condition still holds, in which case setting wins. A 0 leaves the bit unchanged.
- R7: `ien_set` sets and `ien_clr` clears enable bits; clear wins when both name the same bit. `irq` is a register equal to the OR of (status AND enable), updated on the same edge as both.
- R8: Both FIFOs preserve order. `host_we` pushes `host_wdata` into TX and the engine reads the head on `eng_tx_data`, advancing with `eng_tx_pop`. `eng_rx_push` stores `eng_rx_data` and the host sees the head on `host_rdata`, advancing with `host_re`.
- R9: A host push into a full TX FIFO and a host pop from an empty RX FIFO are ignored. They pulse `host_err[0]` and `host_err[1]` respectively for one cycle, on the clock after the attempt.
- R10: `depth_code` reports the parameter n, and each FIFO holds exactly 8 << n bytes (16 by default).
- R11: After reset, status, enables, `irq`, `host_err` and both levels are 0, and both thresholds are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Buffer configuration write strobe |
| cfg_wdata | input | 16 | Thresholds and FIFO clear bits |
| rx_mode | input | 1 | 1: receive transfer, 0: transmit transfer |
| bytes_left | input | CNT_W | Bytes the transfer still has to move |
| host_we | input | 1 | Host data write (TX push) |
| host_wdata | input | DATA_W | Host write data |
| host_re | input | 1 | Host data read (RX pop) |
| host_rdata | output | DATA_W | Head of RX FIFO |
| eng_rx_push | input | 1 | Engine stores a received byte |
| eng_rx_data | input | DATA_W | Received byte |
| eng_tx_pop | input | 1 | Engine takes the TX head |
| eng_tx_data | output | DATA_W | Head of TX FIFO |
| eng_tx_avail | output | 1 | TX FIFO not empty |
| sts_w1c | input | 4 | Write-one-to-clear for status |
| sts | output | 4 | Status: 0 TX request, 1 TX tail, 2 RX request, 3 RX tail |
| ien_set | input | 4 | Enable set strobes |
| ien_clr | input | 4 | Enable clear strobes |
| ien | output | 4 | Enable mask |
| irq | output | 1 | Combined interrupt |
| tx_level | output | DEPTH_CODE+4 | TX FIFO fill level |
| rx_level | output | DEPTH_CODE+4 | RX FIFO fill level |
| depth_code | output | 2 | FIFO depth code n (depth 8 << n) |
| host_err | output | 2 | Bit 0 TX overflow, bit 1 RX underflow pulse |

## Verification
Two pairs of functions can fall in the same cycle. A status clear can land in the same cycle as a still-true condition, and the RX threshold condition can coincide with the end of a receive. The first is provoked by writing ones to the status while the FIFO level and byte count keep the condition alive; the bit must stay set, and it must drop once the count no longer satisfies the condition. The second is provoked by filling the RX FIFO to or past the threshold with `bytes_left` at 0; the judgement is that only the tail bit rises. An enable set and clear aimed at the same bit in one cycle is also driven, and the enable must read back clear with `irq` low.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;
  // status bit positions
  localparam int ST_TX_REQ  = 0;
  localparam int ST_TX_TAIL = 1;
  localparam int ST_RX_REQ  = 2;
  localparam int ST_RX_TAIL = 3;
  localparam int NUM_STS    = 4;
  // configuration word layout
  localparam int THR_W        = 6;
  localparam int CFG_TX_LSB   = 0;
  localparam int CFG_TX_FLUSH = 6;
  localparam int CFG_RX_LSB   = 8;
  localparam int CFG_RX_FLUSH = 14;
endpackage

// File: rtl/fifo_store.sv
module fifo_store #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [AW:0]   level,
  output logic          full,
  output logic          empty
);
  localparam int DEPTH = 1 << AW;
  localparam int LW    = AW + 1;
  localparam logic [AW:0] FULL_LVL = LW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == FULL_LVL);
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  // storage kept free of reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign rdata = mem[rp];
  assign level = cnt;

  // R10
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL_LVL);
  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !flush) |=> (cnt == FULL_LVL));
  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> (cnt == '0));
endmodule

// File: rtl/fifo_flag_eval.sv
module fifo_flag_eval
  import fifo_irq_pkg::*;
#(
  parameter int LW = 5,
  parameter int CW = 16
) (
  input  logic             rx_mode,
  input  logic [CW-1:0]    bytes_left,
  input  logic [LW-1:0]    tx_lvl,
  input  logic [LW-1:0]    rx_lvl,
  input  logic [THR_W-1:0] tx_thr_m1,
  input  logic [THR_W-1:0] rx_thr_m1,
  output logic [NUM_STS-1:0] cond
);
  logic [31:0] tl, rl, bl, tt, rt;
  logic        tx_room, left_nz;

  assign tl = 32'(tx_lvl);
  assign rl = 32'(rx_lvl);
  assign bl = 32'(bytes_left);
  assign tt = 32'(tx_thr_m1) + 32'd1;
  assign rt = 32'(rx_thr_m1) + 32'd1;

  assign tx_room = (tl < tt);
  assign left_nz = (bl != 32'd0);

  always_comb begin
    cond = '0;
    if (!rx_mode) begin
      cond[ST_TX_REQ]  = tx_room && (bl >= tt);
      cond[ST_TX_TAIL] = tx_room && left_nz && (bl < tt);
    end else begin
      // tail has priority: request only while bytes are still coming
      cond[ST_RX_TAIL] = !left_nz && (rl != 32'd0);
      cond[ST_RX_REQ]  = left_nz && (rl >= rt);
    end
  end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import fifo_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_STS-1:0] cond,
  input  logic [NUM_STS-1:0] w1c,
  input  logic [NUM_STS-1:0] en_set,
  input  logic [NUM_STS-1:0] en_clr,
  output logic [NUM_STS-1:0] sts,
  output logic [NUM_STS-1:0] ien,
  output logic               irq
);
  logic [NUM_STS-1:0] sts_q, sts_d, en_q, en_d;
  logic               irq_q;

  assign sts_d = (sts_q & ~w1c) | cond;
  assign en_d  = (en_q | en_set) & ~en_clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= '0;
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      sts_q <= sts_d;
      en_q  <= en_d;
      irq_q <= |(sts_d & en_d);
    end
  end

  assign sts = sts_q;
  assign ien = en_q;
  assign irq = irq_q;

  for (genvar i = 0; i < NUM_STS; i++) begin : g_bit_chk
    // R6
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (w1c[i] && !cond[i]) |=> !sts_q[i]);
    // R6
    cond_set_chk: assert property (@(posedge clk) disable iff (rst)
      cond[i] |=> sts_q[i]);
    // R7
    en_clr_chk: assert property (@(posedge clk) disable iff (rst)
      en_clr[i] |=> !en_q[i]);
  end

  // R3
  tx_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cond[ST_TX_TAIL:ST_TX_REQ]));
  // R5
  rx_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cond[ST_RX_TAIL:ST_RX_REQ]));
endmodule

// File: rtl/fifo_irq_gen.sv
module fifo_irq_gen
  import fifo_irq_pkg::*;
#(
  parameter int DEPTH_CODE = 1,
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [15:0]           cfg_wdata,
  input  logic                  rx_mode,
  input  logic [CNT_W-1:0]      bytes_left,
  input  logic                  host_we,
  input  logic [DATA_W-1:0]     host_wdata,
  input  logic                  host_re,
  output logic [DATA_W-1:0]     host_rdata,
  input  logic                  eng_rx_push,
  input  logic [DATA_W-1:0]     eng_rx_data,
  input  logic                  eng_tx_pop,
  output logic [DATA_W-1:0]     eng_tx_data,
  output logic                  eng_tx_avail,
  input  logic [3:0]            sts_w1c,
  output logic [3:0]            sts,
  input  logic [3:0]            ien_set,
  input  logic [3:0]            ien_clr,
  output logic [3:0]            ien,
  output logic                  irq,
  output logic [DEPTH_CODE+3:0] tx_level,
  output logic [DEPTH_CODE+3:0] rx_level,
  output logic [1:0]            depth_code,
  output logic [1:0]            host_err
);
  localparam int AW = DEPTH_CODE + 3;
  localparam int LW = AW + 1;

  logic [THR_W-1:0] tx_thr_m1, rx_thr_m1;
  logic             tx_flush, rx_flush;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic [1:0]       err_q;
  logic [NUM_STS-1:0] cond;

  assign tx_flush = cfg_we && cfg_wdata[CFG_TX_FLUSH];
  assign rx_flush = cfg_we && cfg_wdata[CFG_RX_FLUSH];

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_thr_m1 <= '0;
      rx_thr_m1 <= '0;
      err_q     <= '0;
    end else begin
      if (cfg_we) begin
        tx_thr_m1 <= cfg_wdata[CFG_TX_LSB +: THR_W];
        rx_thr_m1 <= cfg_wdata[CFG_RX_LSB +: THR_W];
      end
      err_q[0] <= host_we && tx_full;
      err_q[1] <= host_re && rx_empty;
    end
  end

  fifo_store #(.DW(DATA_W), .AW(AW)) u_tx_fifo (
    .clk(clk), .rst(rst), .flush(tx_flush),
    .push(host_we), .wdata(host_wdata),
    .pop(eng_tx_pop), .rdata(eng_tx_data),
    .level(tx_level), .full(tx_full), .empty(tx_empty)
  );

  fifo_store #(.DW(DATA_W), .AW(AW)) u_rx_fifo (
    .clk(clk), .rst(rst), .flush(rx_flush),
    .push(eng_rx_push), .wdata(eng_rx_data),
    .pop(host_re), .rdata(host_rdata),
    .level(rx_level), .full(rx_full), .empty(rx_empty)
  );

  fifo_flag_eval #(.LW(LW), .CW(CNT_W)) u_eval (
    .rx_mode(rx_mode), .bytes_left(bytes_left),
    .tx_lvl(tx_level), .rx_lvl(rx_level),
    .tx_thr_m1(tx_thr_m1), .rx_thr_m1(rx_thr_m1),
    .cond(cond)
  );

  irq_status_reg u_sts (
    .clk(clk), .rst(rst), .cond(cond), .w1c(sts_w1c),
    .en_set(ien_set), .en_clr(ien_clr),
    .sts(sts), .ien(ien), .irq(irq)
  );

  assign eng_tx_avail = !tx_empty;
  assign depth_code   = 2'(DEPTH_CODE);
  assign host_err     = err_q;

  // R9
  rx_full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_rx_push && rx_full && !host_re && !rx_flush) |=> (rx_level == $past(rx_level)));
  // R1
  tx_flush_chk: assert property (@(posedge clk) disable iff (rst)
    tx_flush |=> (tx_level == '0));
endmodule

// File: tb/fifo_irq_gen_tb.sv
module fifo_irq_gen_tb_top;
  localparam int CLK_P = 10;
  localparam int NV = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 0;
  logic [15:0] cfg_wdata = 0;
  logic rx_mode = 0;
  logic [15:0] bytes_left = 0;
  logic host_we = 0, host_re = 0, eng_rx_push = 0, eng_tx_pop = 0;
  logic [7:0] host_wdata = 0, eng_rx_data = 0;
  logic [7:0] host_rdata, eng_tx_data;
  logic eng_tx_avail, irq;
  logic [3:0] sts_w1c = 0, ien_set = 0, ien_clr = 0, sts, ien;
  logic [4:0] tx_level, rx_level;
  logic [1:0] depth_code, host_err;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  fifo_irq_gen dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .rx_mode(rx_mode), .bytes_left(bytes_left),
    .host_we(host_we), .host_wdata(host_wdata), .host_re(host_re),
    .host_rdata(host_rdata), .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
    .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data), .eng_tx_avail(eng_tx_avail),
    .sts_w1c(sts_w1c), .sts(sts), .ien_set(ien_set), .ien_clr(ien_clr),
    .ien(ien), .irq(irq), .tx_level(tx_level), .rx_level(rx_level),
    .depth_code(depth_code), .host_err(host_err)
  );

  // {rx_mode, threshold, fill level, bytes_left, expected status}
  localparam logic [31:0] VEC [NV] = '{
    {1'b0, 6'd4, 5'd0, 16'd10, 4'b0001},  // R2 room and many bytes
    {1'b0, 6'd4, 5'd0, 16'd3,  4'b0010},  // R3 short tail
    {1'b0, 6'd4, 5'd4, 16'd10, 4'b0000},  // R2 level at threshold
    {1'b0, 6'd4, 5'd3, 16'd2,  4'b0010},  // R3
    {1'b0, 6'd4, 5'd2, 16'd0,  4'b0000},  // R3 nothing left
    {1'b0, 6'd1, 5'd0, 16'd5,  4'b0001},  // R2 threshold one
    {1'b1, 6'd4, 5'd4, 16'd5,  4'b0100},  // R4
    {1'b1, 6'd4, 5'd2, 16'd5,  4'b0000},  // R4 below threshold
    {1'b1, 6'd4, 5'd2, 16'd0,  4'b1000},  // R5 tail
    {1'b1, 6'd4, 5'd5, 16'd0,  4'b1000},  // R5 precedence over request
    {1'b1, 6'd4, 5'd0, 16'd0,  4'b0000},  // R5 empty
    {1'b1, 6'd1, 5'd1, 16'd3,  4'b0100}   // R4 threshold one
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [15:0] w);
    cfg_we = 1; cfg_wdata = w;
    tick(1);
    cfg_we = 0; cfg_wdata = 0;
  endtask

  initial begin
    tick(3);
    rst = 0;
    tick(1);
    // R11 reset state, R10 depth code
    check("R11 sts", sts, 0);
    check("R11 ien", ien, 0);
    check("R11 irq", irq, 0);
    check("R11 tx_level", tx_level, 0);
    check("R11 rx_level", rx_level, 0);
    check("R11 host_err", host_err, 0);
    check("R10 depth_code", depth_code, 1);
    // R11 threshold defaults to 1: empty TX, 1 byte left -> TX request
    bytes_left = 1;
    tick(2);
    check("R11 default threshold", sts, 1);
    sts_w1c = 4'hF; bytes_left = 0; tick(1); sts_w1c = 0; tick(1);

    for (int v = 0; v < NV; v++) begin
      logic [5:0] m1;
      logic [4:0] lvl;
      m1 = VEC[v][30:25] - 6'd1;
      lvl = VEC[v][24:20];
      rx_mode = VEC[v][31];
      bytes_left = VEC[v][19:4];
      cfg_write({2'b01, m1, 2'b01, m1});
      for (int k = 0; k < int'(lvl); k++) begin
        if (rx_mode) begin eng_rx_push = 1; eng_rx_data = 8'(k); end
        else begin host_we = 1; host_wdata = 8'(k); end
        tick(1);
        eng_rx_push = 0; host_we = 0;
      end
      tick(2);
      sts_w1c = 4'hF; tick(1); sts_w1c = 0;
      check($sformatf("R2-5 vector %0d (R2 R3 R4 R5)", v), sts, int'(VEC[v][3:0]));
    end

    // R6 sticky, write-0, clear-vs-set
    rx_mode = 0; bytes_left = 10;
    cfg_write(16'h4343);              // thresholds 4, both FIFOs emptied
    tick(2);
    sts_w1c = 4'hF; tick(1); sts_w1c = 0;
    bytes_left = 0; tick(2);
    check("R6 sticky after condition gone", sts, 1);
    sts_w1c = 4'b0010; tick(1); sts_w1c = 0;
    check("R6 zero bit has no effect", sts, 1);
    sts_w1c = 4'b0001; tick(1); sts_w1c = 0;
    check("R6 one clears", sts, 0);
    bytes_left = 10; tick(2);
    sts_w1c = 4'b0001; tick(1); sts_w1c = 0;
    check("R6 set wins over clear", sts, 1);

    // R7 enable and irq
    ien_set = 4'b0001; tick(1); ien_set = 0;
    check("R7 ien set", ien, 1);
    check("R7 irq high", irq, 1);
    ien_set = 4'b0001; ien_clr = 4'b0001; tick(1); ien_set = 0; ien_clr = 0;
    check("R7 clear wins", ien, 0);
    check("R7 irq low", irq, 0);
    ien_set = 4'b0010; tick(1); ien_set = 0;
    check("R7 masked status no irq", irq, 0);

    // R10 full depth and R9 overflow
    for (int k = 0; k < 16; k++) begin
      host_we = 1; host_wdata = 8'(k + 16); tick(1);
    end
    host_we = 0;
    check("R10 tx full level", tx_level, 16);
    check("R9 no error yet", host_err, 0);
    host_we = 1; host_wdata = 8'hEE; tick(1); host_we = 0;
    check("R9 overflow flagged", host_err, 1);
    check("R9 overflow ignored", tx_level, 16);
    tick(1);
    check("R9 pulse ends", host_err, 0);
    // R8 TX order
    check("R8 tx head", eng_tx_data, 16);
    eng_tx_pop = 1; tick(1); eng_tx_pop = 0;
    check("R8 tx next", eng_tx_data, 17);

    // R9 underflow
    host_re = 1; tick(1); host_re = 0;
    check("R9 underflow flagged", host_err, 2);
    check("R9 underflow ignored", rx_level, 0);

    // R8 RX order
    eng_rx_push = 1; eng_rx_data = 8'hA5; tick(1);
    eng_rx_data = 8'h3C; tick(1); eng_rx_push = 0;
    check("R8 rx head", host_rdata, 8'hA5);
    host_re = 1; tick(1); host_re = 0;
    check("R8 rx next", host_rdata, 8'h3C);
    check("R8 rx level", rx_level, 1);

    // R1 TX clear leaves RX untouched
    cfg_write(16'h0040);
    check("R1 tx emptied", tx_level, 0);
    check("R1 rx kept", rx_level, 1);
    check("R1 avail low", eng_tx_avail, 0);
    cfg_write(16'h4000);
    check("R1 rx emptied", rx_level, 0);

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule